// File: doc/BRIEF.md
# Cascadable 16/32-bit Timer Pair

The block holds two general-purpose timers: a low-word unit and a high-word unit. Each unit has a control register, a period register and a count register, and its own prescaler. A unit counts one of three kinds of event:
- every cycle of the system clock (timer mode);
- system clock cycles while its external pin is high (gated mode);
- synchronized rising edges on its external pin (counter mode).

When the count reaches the period on a prescaled tick, the count returns to zero and a one-cycle interrupt pulse is raised.

A chain bit in the low unit's control register joins the two units into one 32-bit timer. The low unit's control settings then drive both halves, and the low unit's external pin supplies the events. The count and the period are each compared as the 32-bit value {high, low}. The match pulse, and the gate-fall pulse, appear on the high unit's interrupt output. The high unit's own control settings play no part in counting while the units are chained.

Software reaches the registers through a simple write port and a registered read port. Read data appears one clock after the read address is applied.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, every register reads 0 and both interrupt outputs are low.
- R2: Register map (address bit 2 selects the unit, 0 low and 1 high; bits 1:0 select control 0, period 1, count 2).
  - Control bits: bit 1 is clock source (1 = external counter), bit 3 is chain (low unit only), bits 5:4 are prescale, bit 6 is gate enable and bit 15 is run.
  - Bits outside these read 0. The high unit's bit 3 also reads 0.
- R3: In timer mode (source 0, gate 0) with prescale 00, a running unit with period P pulses its interrupt every P+1 clocks.
- R4: Prescale codes 00, 01, 10 and 11 divide the event rate by 1, 8, 64 and 256. The interrupt interval becomes (P+1) times the ratio.
- R5: While the run bit is 0, the count holds its value.
- R6: Writing a count register loads the new value on that clock edge. The load takes precedence over counting.
- R7: In counter mode (source 1, gate bit ignored), each rising edge on the unit's external pin adds one count after a two-flop synchronizer. The system clock alone adds nothing. A match on the period resets the count and raises the interrupt.
- R8: In gated mode (source 0, gate 1), the count advances once per clock while the synchronized pin is high. The interrupt is raised once on the pin's falling edge and never on a period match.
- R9: With the chain bit set, the pair counts as one 32-bit value with carry from the low half into the high half. A match against the 32-bit period {high period, low period} zeroes both halves and pulses the high interrupt. The low interrupt stays low.
- R10: While chained, the high unit's run and prescale bits have no effect on the 32-bit count.
- R11: Each interrupt is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (bit 2 unit, bits 1:0 register) |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | W | Registered read data |
| ext_lo | input | 1 | Low unit external pin (counter clock or gate) |
| ext_hi | input | 1 | High unit external pin (counter clock or gate) |
| irq_lo | output | 1 | Low unit interrupt pulse |
| irq_hi | output | 1 | High unit interrupt pulse (the 32-bit interrupt when chained) |

## Verification
Interrupt intervals are measured for each prescale code. An off-by-one in the match or in the prescaler limit shows up as an interval of P clocks, or as a multiple of the wrong ratio.

In gated mode the gate is held high for a known number of clocks against a small period. This catches a design that counts one extra or one short across the synchronizer, and one that raises pulses on period match as well as on the falling edge.

The chained case starts just below the low-half rollover. The high unit is left stopped and set to the slowest prescale. A missing carry, a 16-bit-only comparison, interrupt routing to the low output, or obedience to the high unit's control bits each gives a wrong count, a wrong match cycle or a stray low pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CB_SRC   = 1;
  localparam int CB_CHAIN = 3;
  localparam int CB_PSC   = 4;
  localparam int CB_GATE  = 6;
  localparam int CB_RUN   = 15;
  localparam int PSC_W    = 8;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_PER  = 2'd1;
  localparam logic [1:0] RG_CNT  = 2'd2;

  typedef enum logic [1:0] {MD_TIMER, MD_GATED, MD_COUNT} mode_e;

  function automatic mode_e mode_of(input logic src, input logic gate);
    if (src) return MD_COUNT;
    if (gate) return MD_GATED;
    return MD_TIMER;
  endfunction

  // last prescaler count value before a tick is issued
  function automatic logic [PSC_W-1:0] psc_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return PSC_W'(0);
      2'b01:   return PSC_W'(7);
      2'b10:   return PSC_W'(63);
      default: return PSC_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], d};
  end

  assign q      = sh[STAGES-1];
  assign q_prev = sh[STAGES];
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
  import tmr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_in,
  input  logic       run,
  input  logic       clr,
  input  mode_e      mode,
  input  logic [1:0] psc,
  output logic       tick,
  output logic       gate_fall
);
  logic             lvl, lvl_prev, rise, fall, ev;
  logic [PSC_W-1:0] pcnt, lim;

  tmr_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ext_in), .q(lvl), .q_prev(lvl_prev)
  );

  assign rise = lvl & ~lvl_prev;
  assign fall = ~lvl & lvl_prev;
  assign lim  = psc_limit(psc);

  always_comb begin
    case (mode)
      MD_COUNT: ev = rise;
      MD_GATED: ev = lvl;
      default:  ev = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pcnt <= '0;
    else if (ev)            pcnt <= (pcnt == lim) ? '0 : pcnt + 1'b1;
  end

  assign tick      = run && ev && (pcnt == lim);
  assign gate_fall = run && (mode == MD_GATED) && fall;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         ext_lo,
  input  logic         ext_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int NU = 2;
  localparam int DW = 2 * W;

  function automatic logic [W-1:0] ctrl_mask(input logic has_chain);
    logic [W-1:0] m;
    m = '0;
    m[CB_SRC] = 1'b1;
    m[CB_CHAIN] = has_chain;
    m[CB_PSC +: 2] = 2'b11;
    m[CB_GATE] = 1'b1;
    m[CB_RUN] = 1'b1;
    return m;
  endfunction

  logic [W-1:0] ctrl_q [NU];
  logic [W-1:0] per_q  [NU];
  logic [W-1:0] cnt_q  [NU];
  logic [W-1:0] cnt_d  [NU];
  logic [NU-1:0] irq_q, irq_d, tick, fall, clr;
  mode_e        mode [NU];
  logic [NU-1:0] ext_in;
  logic         chain;
  logic [DW-1:0] c32, p32, n32;

  assign ext_in = {ext_hi, ext_lo};
  assign chain  = ctrl_q[0][CB_CHAIN];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign mode[u] = mode_of(ctrl_q[u][CB_SRC], ctrl_q[u][CB_GATE]);
    assign clr[u]  = wr_en && (wr_addr[2] == 1'(u)) && (wr_addr[1:0] == RG_CTRL);

    tmr_tick #(.STAGES(STAGES)) u_tick (
      .clk(clk), .rst(rst), .ext_in(ext_in[u]),
      .run(ctrl_q[u][CB_RUN]), .clr(clr[u]), .mode(mode[u]),
      .psc(ctrl_q[u][CB_PSC +: 2]),
      .tick(tick[u]), .gate_fall(fall[u])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[u] <= '0;
        per_q[u]  <= '0;
      end else if (wr_en && (wr_addr[2] == 1'(u))) begin
        if (wr_addr[1:0] == RG_CTRL) ctrl_q[u] <= wr_data & ctrl_mask(u == 0);
        if (wr_addr[1:0] == RG_PER)  per_q[u]  <= wr_data;
      end
    end
  end

  assign c32 = {cnt_q[1], cnt_q[0]};
  assign p32 = {per_q[1], per_q[0]};

  always_comb begin
    irq_d = '0;
    n32   = c32;
    for (int u = 0; u < NU; u++) cnt_d[u] = cnt_q[u];
    if (chain) begin
      if (tick[0]) begin
        if (c32 == p32) begin
          n32 = '0;
          if (mode[0] != MD_GATED) irq_d[1] = 1'b1;
        end else begin
          n32 = c32 + 1'b1;
        end
      end
      if (fall[0]) irq_d[1] = 1'b1;
      cnt_d[0] = n32[W-1:0];
      cnt_d[1] = n32[DW-1:W];
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (tick[u]) begin
          if (cnt_q[u] == per_q[u]) begin
            cnt_d[u] = '0;
            if (mode[u] != MD_GATED) irq_d[u] = 1'b1;
          end else begin
            cnt_d[u] = cnt_q[u] + 1'b1;
          end
        end
        if (fall[u]) irq_d[u] = 1'b1;
      end
    end
    for (int u = 0; u < NU; u++)
      if (wr_en && (wr_addr[2] == u[0]) && (wr_addr[1:0] == RG_CNT))
        cnt_d[u] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NU; u++) cnt_q[u] <= '0;
      irq_q   <= '0;
      rd_data <= '0;
    end else begin
      for (int u = 0; u < NU; u++) cnt_q[u] <= cnt_d[u];
      irq_q <= irq_d;
      case (rd_addr[1:0])
        RG_CTRL: rd_data <= ctrl_q[rd_addr[2]];
        RG_PER:  rd_data <= per_q[rd_addr[2]];
        RG_CNT:  rd_data <= cnt_q[rd_addr[2]];
        default: rd_data <= '0;
      endcase
    end
  end

  assign irq_lo = irq_q[0];
  assign irq_hi = irq_q[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic [W-1:0] ctrl_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi
);
  // R1: reset clears counts and interrupts
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && !irq_lo && !irq_hi));

  // R5: stopped low unit keeps its count unless software loads it
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_lo[CB_RUN] && !(wr_en && wr_addr == 3'd2)) |=> $stable(cnt_lo));

  // R6: a count write lands on that edge
  assert_load_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd2) |=> (cnt_lo == $past(wr_data)));

  assert_load_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd6) |=> (cnt_hi == $past(wr_data)));

  // R9: chained pair never pulses the low interrupt
  assert_lo_quiet_chained_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_lo[CB_CHAIN]) |-> !irq_lo);
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .ctrl_lo(ctrl_q[0]),
  .cnt_lo(cnt_q[0]), .cnt_hi(cnt_q[1])
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 0, rst = 1, wr_en = 0, ext_lo = 0, ext_hi = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic irq_lo, irq_hi;
  int n_chk = 0, n_bad = 0, n_irq_lo = 0, n_irq_hi = 0;

  tmr_pair #(.W(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_lo(ext_lo), .ext_hi(ext_hi),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (irq_lo) n_irq_lo++;
    if (irq_hi) n_irq_hi++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic gap(input bit hi, output int g);
    int t;
    t = 0;
    do begin @(negedge clk); t++; end while (!(hi ? irq_hi : irq_lo) && t < 5000);
    g = 0;
    do begin @(negedge clk); g++; end while (!(hi ? irq_hi : irq_lo) && g < 5000);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_lo = 1;
      repeat (4) @(negedge clk);
      ext_lo = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      if (a == 3 || a == 7) continue;
      rd(3'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq_lo reset", int'(irq_lo), 0);
    check("R1 irq_hi reset", int'(irq_hi), 0);
  endtask

  task automatic t_map();
    int v;
    wr(3'd0, 16'h7FFF); rd(3'd0, v); check("R2 low ctrl readback", v, 'h007A);
    wr(3'd4, 16'h7FFF); rd(3'd4, v); check("R2 high ctrl readback", v, 'h0072);
    wr(3'd5, 16'hBEEF); rd(3'd5, v); check("R2 high period readback", v, 'hBEEF);
    wr(3'd0, 0); wr(3'd4, 0); wr(3'd5, 0);
  endtask

  task automatic t_timer();
    int g, base;
    wr(3'd1, 9); wr(3'd2, 0); wr(3'd0, 16'h8000);
    gap(0, g); check("R3 period 9 interval", g, 10);
    base = n_irq_lo;
    repeat (100) @(negedge clk);
    check("R11 pulses in 100 clocks", n_irq_lo - base, 10);
    wr(3'd0, 0);
  endtask

  task automatic t_psc();
    int g;
    wr(3'd1, 4); wr(3'd2, 0); wr(3'd0, 16'h8010);
    gap(0, g); check("R4 div8 period 4", g, 40);
    wr(3'd1, 1); wr(3'd0, 16'h8020);
    gap(0, g); check("R4 div64 period 1", g, 128);
    wr(3'd1, 0); wr(3'd0, 16'h8030);
    gap(0, g); check("R4 div256 period 0", g, 256);
    wr(3'd0, 0);
    wr(3'd5, 9); wr(3'd6, 0); wr(3'd4, 16'h8010);
    gap(1, g); check("R4 high unit div8 period 9", g, 80);
    wr(3'd4, 0);
  endtask

  task automatic t_stop_load();
    int a, b;
    wr(3'd1, 1000); wr(3'd2, 0); wr(3'd0, 16'h8000);
    repeat (30) @(negedge clk);
    wr(3'd0, 0);
    rd(3'd2, a);
    repeat (20) @(negedge clk);
    rd(3'd2, b);
    check("R5 count held while stopped", b, a);
    check("R5 count advanced before stop", int'(a > 20), 1);
    wr(3'd2, 16'h1234); rd(3'd2, a); check("R6 low count load", a, 'h1234);
    wr(3'd6, 16'hA5A5); rd(3'd6, a); check("R6 high count load", a, 'hA5A5);
    wr(3'd6, 0);
  endtask

  task automatic t_count();
    int v, base;
    wr(3'd1, 1000); wr(3'd2, 0); wr(3'd0, 16'h8042);
    repeat (50) @(negedge clk);
    rd(3'd2, v); check("R7 no count from system clock", v, 0);
    pulses(5);
    repeat (6) @(negedge clk);
    rd(3'd2, v); check("R7 five edges counted", v, 5);
    wr(3'd0, 0); wr(3'd1, 2); wr(3'd2, 0); wr(3'd0, 16'h8002);
    base = n_irq_lo;
    pulses(3); repeat (6) @(negedge clk);
    check("R7 match after 3 edges", n_irq_lo - base, 1);
    pulses(3); repeat (6) @(negedge clk);
    check("R7 second match after 3 more", n_irq_lo - base, 2);
    wr(3'd0, 0);
  endtask

  task automatic t_gate();
    int v, base;
    wr(3'd1, 1000); wr(3'd2, 0); wr(3'd0, 16'h8040);
    repeat (20) @(negedge clk);
    rd(3'd2, v); check("R8 no count while gate low", v, 0);
    base = n_irq_lo;
    @(negedge clk); ext_lo = 1;
    repeat (50) @(negedge clk);
    ext_lo = 0;
    repeat (10) @(negedge clk);
    rd(3'd2, v); check("R8 counts while gate high", v, 50);
    check("R8 one pulse on falling gate", n_irq_lo - base, 1);
    wr(3'd0, 0); wr(3'd1, 9); wr(3'd2, 0); wr(3'd0, 16'h8040);
    base = n_irq_lo;
    @(negedge clk); ext_lo = 1;
    repeat (30) @(negedge clk);
    ext_lo = 0;
    repeat (10) @(negedge clk);
    check("R8 no pulse on period match", n_irq_lo - base, 1);
    wr(3'd0, 0);
  endtask

  task automatic t_chain();
    int v, lo0, hi0, hit;
    wr(3'd4, 16'h0030);
    wr(3'd5, 16'hFFFF); wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFE); wr(3'd6, 0);
    lo0 = n_irq_lo; hi0 = n_irq_hi;
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 16'h8008;
    @(posedge clk); #1 wr_en = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 16'h0008;
    @(negedge clk); wr_en = 0;
    rd(3'd2, v); check("R9 low half after carry", v, 4);
    rd(3'd6, v); check("R10 high half carried, high ctrl ignored", v, 1);
    wr(3'd5, 1); wr(3'd1, 4); wr(3'd2, 16'hFFFE); wr(3'd6, 0);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 16'h8008;
    @(posedge clk); #1 wr_en = 0;
    hit = 0;
    for (int i = 1; i <= 12; i++) begin
      @(posedge clk); #1;
      if (irq_hi && hit == 0) hit = i;
    end
    check("R9 32-bit match cycle", hit, 7);
    wr(3'd0, 0);
    rd(3'd6, v); check("R9 high half wrapped", v, 0);
    check("R9 low irq silent while chained", n_irq_lo - lo0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_map();
    t_timer();
    t_psc();
    t_stop_load();
    t_count();
    t_gate();
    t_chain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule